// File: doc/BRIEF.md
# Cycle Counter with Control Register

This block keeps a 32-bit count of core clock cycles for a processor's performance-monitor unit. Software drives it through a single-cycle register port. Each request carries a privilege flag. The control word turns counting on and off, freezes it, selects a divide-by-64 prescale, and can clear the count. Software can read the counter at any time, and a privileged write can preload it.

The request port takes one request per cycle with no back-pressure. There is no ready signal, and every request presented with `req_valid` high is accepted in that cycle. The response comes back on the next cycle: `rsp_valid` is high, `rsp_rdata` carries the read value, and `rsp_err` flags a rejected access. The address map has two registers. Word 0 is the control register and word 1 is the counter. Every other address is unmapped.

Control fields (bit position is behaviour, since software encodes these values):

| Bit | Meaning |
|-----|---------|
| 0 | run enable |
| 2 | clear request (write-only, self-clearing) |
| 3 | divide the count rate by 64 |
| 4 | spare, stored |
| 5 | freeze |

Top module: `pmu_cycle_counter`

## Requirements
- R1: After reset the counter reads 0, the control register reads 0, and no response is pending.
- R2: While control bit 0 is 1 and bit 5 is 0 with bit 3 clear, the counter rises by exactly one per cycle. The first increment occurs one cycle after the write that sets bit 0.
- R3: A control write with bit 2 set clears the counter and the prescaler at that clock edge, and bit 2 always reads back as 0.
- R4: With bit 3 set, the counter rises once per 64 counting cycles. The first increment comes 64 counting cycles after a clear.
- R5: While bit 5 is 1 or bit 0 is 0, both the counter and the prescaler hold their values.
- R6: A control write stores only the bits in mask 0x39, and all other bits read back as 0.
- R7: A control access (read or write) with `req_priv` low and `user_en` low returns `rsp_err`=1 with data 0 and changes no state. With `user_en` high, it is served normally.
- R8: A counter access with `req_priv` low returns `rsp_err`=1 with data 0 regardless of `user_en`, and does not load the counter.
- R9: A privileged counter write loads the written value, and counting resumes from that value on the next cycle.
- R10: The counter wraps from 0xFFFFFFFF to 0.
- R11: The response appears one cycle after the request. Reads return the register value from the cycle the request was presented. Writes return data 0. An unmapped address returns `rsp_err`=1 with data 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | word address (0 control, 1 counter) |
| req_wdata | input | CNT_W | write data |
| req_priv | input | 1 | 1 = privileged requester |
| user_en | input | 1 | grants unprivileged control access |
| rsp_valid | output | 1 | response for the previous cycle's request |
| rsp_rdata | output | CNT_W | read data, 0 for writes and errors |
| rsp_err | output | 1 | access rejected |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, a 4-bit address and a 6-bit prescaler. With these values a full 64-cycle prescale period fits comfortably in a short run, as does a freeze in the middle of a period. The wrap boundary is reached by preloading the counter a few counts below its maximum instead of counting up to it. The bench compares every response with a behavioural model while the control word moves through enable, clear, prescale, freeze and denied-access sequences.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CTL_W  = 6;
  localparam int B_EN   = 0;
  localparam int B_CLR  = 2;
  localparam int B_DIV  = 3;
  localparam int B_HALT = 5;
  localparam logic [CTL_W-1:0] CTL_KEEP = 6'h39;

  typedef enum logic [1:0] {
    RG_CTRL  = 2'd0,
    RG_COUNT = 2'd1,
    RG_NONE  = 2'd2
  } region_e;

  typedef struct packed {
    logic ctl_we;
    logic clr;
    logic cnt_we;
  } cmd_t;
endpackage

// File: rtl/cc_access.sv
module cc_access
  import cc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_priv,
  input  logic              user_en,
  input  logic [CTL_W-1:0]  ctl_q,
  input  logic [DATA_W-1:0] cnt_q,
  output cmd_t              cmd,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CNT  = ADDR_W'(1);

  region_e           rg;
  logic              allow;
  logic              fire;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    if (req_addr == ADDR_CTRL)     rg = RG_CTRL;
    else if (req_addr == ADDR_CNT) rg = RG_COUNT;
    else                           rg = RG_NONE;

    case (rg)
      RG_CTRL:  allow = req_priv | user_en;
      RG_COUNT: allow = req_priv;
      default:  allow = 1'b0;
    endcase

    fire       = req_valid & allow;
    cmd.ctl_we = fire & req_write & (rg == RG_CTRL);
    cmd.clr    = cmd.ctl_we & req_wdata[B_CLR];
    cmd.cnt_we = fire & req_write & (rg == RG_COUNT);

    rd_next = '0;
    if (fire && !req_write) begin
      if (rg == RG_CTRL) rd_next = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
      else               rd_next = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid & ~allow;
      rsp_rdata <= rd_next;
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R11
  AST_CNT_USER_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_priv && req_addr == ADDR_CNT |=> rsp_err && rsp_rdata == '0); // R8
  AST_CTRL_USER_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_priv && !user_en && req_addr == ADDR_CTRL |=> rsp_err); // R7
endmodule

// File: rtl/cc_prescale.sv
module cc_prescale #(
  parameter int PRE_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic clr,
  output logic tick
);
  generate
    if (PRE_W == 0) begin : g_nodiv
      assign tick = adv;
    end else begin : g_div
      logic [PRE_W-1:0] pre_q;

      assign tick = adv & (&pre_q);

      always_ff @(posedge clk) begin
        if (!rst_n)   pre_q <= '0;
        else if (clr) pre_q <= '0;
        else if (adv) pre_q <= pre_q + 1'b1;
      end

      AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv && !clr |=> $stable(pre_q)); // R5
      AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> pre_q == '0); // R3
    end
  endgenerate
endmodule

// File: rtl/cc_count.sv
module cc_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0); // R3
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load && !clr |=> cnt_q == $past(load_val)); // R9
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clr && !load |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clr && !load && (&cnt_q) |=> cnt_q == '0); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !clr && !load |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter
  import cc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_wdata,
  input  logic              req_priv,
  input  logic              user_en,
  output logic              rsp_valid,
  output logic [CNT_W-1:0]  rsp_rdata,
  output logic              rsp_err
);
  cmd_t             cmd;
  logic [CTL_W-1:0] ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             counting;
  logic             divided;
  logic             pre_tick;
  logic             step;

  always_ff @(posedge clk) begin
    if (!rst_n)          ctl_q <= '0;
    else if (cmd.ctl_we) ctl_q <= req_wdata[CTL_W-1:0] & CTL_KEEP;
  end

  assign counting = ctl_q[B_EN] & ~ctl_q[B_HALT];
  assign divided  = ctl_q[B_DIV];
  assign step     = counting & (~divided | pre_tick);

  cc_access #(.ADDR_W(ADDR_W), .DATA_W(CNT_W)) u_access (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_priv  (req_priv),
    .user_en   (user_en),
    .ctl_q     (ctl_q),
    .cnt_q     (cnt_q),
    .cmd       (cmd),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  cc_prescale #(.PRE_W(PRE_W)) u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (counting & divided),
    .clr   (cmd.clr),
    .tick  (pre_tick)
  );

  cc_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cmd.clr),
    .load     (cmd.cnt_we),
    .load_val (req_wdata),
    .step     (step),
    .cnt_q    (cnt_q)
  );

  AST_CTRL_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & ~CTL_KEEP) == '0); // R6
  AST_CTRL_DENY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_addr == ADDR_W'(0) && !req_priv && !user_en
    |=> $stable(ctl_q)); // R7
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[B_HALT] && !cmd.clr && !cmd.cnt_we |=> $stable(cnt_q)); // R5
endmodule

// File: tb/pmu_cycle_counter_bench.sv
`timescale 1ns/1ps
module pmu_cycle_counter_bench;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0]  req_wdata = '0;
  logic              req_priv = 1'b0;
  logic              user_en = 1'b0;
  logic              rsp_valid;
  logic [CNT_W-1:0]  rsp_rdata;
  logic              rsp_err;

  int    tests = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  pmu_cycle_counter #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .PRE_W(6)) u_pmu_cycle_counter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_priv(req_priv),
    .user_en(user_en), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  // Behavioural reference model
  logic [5:0]  m_ctl;
  logic [31:0] m_cnt;
  int          m_pre;
  bit          e_valid;
  bit          e_err;
  logic [31:0] e_rdata;
  string       e_tag = "R1";

  always @(posedge clk) begin
    bit ok, clr, ld, run, tick;
    logic [31:0] rd;
    if (!rst_n) begin
      m_ctl = '0; m_cnt = '0; m_pre = 0;
      e_valid = 0; e_err = 0; e_rdata = '0;
    end else begin
      ok = 0; clr = 0; ld = 0; rd = '0;
      run  = m_ctl[0] && !m_ctl[5];
      tick = run && (!m_ctl[3] || m_pre == 63);
      if (req_valid) begin
        if (req_addr == 0) ok = req_priv || user_en;
        else if (req_addr == 1) ok = req_priv;
        if (ok && !req_write) rd = (req_addr == 0) ? {26'd0, m_ctl} : m_cnt;
      end
      e_valid = req_valid;
      e_err   = req_valid && !ok;
      e_rdata = rd;
      e_tag   = cur_tag;
      if (req_valid && ok && req_write && req_addr == 1) ld = 1;
      if (req_valid && ok && req_write && req_addr == 0) begin
        clr = req_wdata[2];
      end
      if (clr) begin
        m_cnt = '0; m_pre = 0;
      end else begin
        if (run && m_ctl[3]) m_pre = (m_pre + 1) % 64;
        if (ld) m_cnt = req_wdata;
        else if (tick) m_cnt = m_cnt + 32'd1;
      end
      if (req_valid && ok && req_write && req_addr == 0) m_ctl = req_wdata[5:0] & 6'h39;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done && (e_valid || rsp_valid)) begin
      tests++;
      if (rsp_valid !== e_valid || rsp_err !== e_err || rsp_rdata !== e_rdata) begin
        fails++;
        $display("FAIL %s: valid/err/data %0b/%0b/%h expected %0b/%0b/%h",
                 e_tag, rsp_valid, rsp_err, rsp_rdata, e_valid, e_err, e_rdata);
      end
    end
  end

  task automatic acc(input bit w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                     input bit p, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_priv = p;
    cur_tag = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; cur_tag = tag;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tests++;  // R1: nothing pending right after reset
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: rsp_valid %0b expected 0", rsp_valid);
    end
    acc(0, 0, 0, 1, "R1");
    acc(0, 1, 0, 1, "R1");
    idle(3, "R1");

    // R2: plain counting
    acc(1, 0, 32'h1, 1, "R2");
    idle(3, "R2");
    for (int i = 0; i < 6; i++) acc(0, 1, 0, 1, "R2");

    // R6: write mask, enable with freeze
    acc(1, 0, 32'hFFFF_FFFF, 1, "R6");
    acc(0, 0, 0, 1, "R6");
    acc(0, 1, 0, 1, "R6");
    idle(4, "R6");
    acc(0, 1, 0, 1, "R6");
    acc(1, 0, 32'h1, 1, "R6");
    idle(10, "R3");

    // R3: clear with enable
    acc(1, 0, 32'h5, 1, "R3");
    acc(0, 1, 0, 1, "R3");
    acc(0, 0, 0, 1, "R3");
    acc(0, 1, 0, 1, "R3");

    // R4: prescaled count
    acc(1, 0, 32'hD, 1, "R4");
    for (int i = 0; i < 140; i++) acc(0, 1, 0, 1, "R4");

    // R5: freeze mid period, then disable, then resume
    acc(1, 0, 32'h29, 1, "R5");
    idle(20, "R5");
    acc(0, 1, 0, 1, "R5");
    acc(1, 0, 32'h08, 1, "R5");
    idle(10, "R5");
    acc(0, 1, 0, 1, "R5");
    acc(1, 0, 32'h09, 1, "R5");
    for (int i = 0; i < 70; i++) acc(0, 1, 0, 1, "R5");

    // R7: unprivileged control access
    acc(1, 0, 32'h1, 1, "R7");
    user_en = 1'b0;
    acc(1, 0, 32'h0, 0, "R7");
    acc(0, 0, 0, 0, "R7");
    acc(0, 0, 0, 1, "R7");
    acc(0, 1, 0, 1, "R7");
    acc(0, 1, 0, 1, "R7");
    user_en = 1'b1;
    acc(1, 0, 32'h9, 0, "R7");
    acc(0, 0, 0, 0, "R7");
    acc(1, 0, 32'h1, 0, "R7");

    // R8: unprivileged counter access, even with user_en
    acc(0, 1, 0, 0, "R8");
    acc(1, 1, 32'h1234, 0, "R8");
    acc(0, 1, 0, 1, "R8");
    user_en = 1'b0;

    // R9: preload
    acc(1, 1, 32'h1234_5678, 1, "R9");
    for (int i = 0; i < 4; i++) acc(0, 1, 0, 1, "R9");

    // R10: wrap
    acc(1, 1, 32'hFFFF_FFFD, 1, "R10");
    for (int i = 0; i < 6; i++) acc(0, 1, 0, 1, "R10");

    // R11: unmapped addresses and write data
    acc(0, 4'h7, 0, 1, "R11");
    acc(1, 4'hF, 32'hABCD, 1, "R11");
    acc(1, 0, 32'h1, 1, "R11");
    acc(0, 1, 0, 1, "R11");
    idle(4, "R11");

    finish_run();
  end
endmodule